// File: doc/BRIEF.md
# Plane Intra Predictor Parameter Unit

This unit derives the three numbers that drive a 16x16 plane (gradient) intra predictor. The inputs are the 16 reconstructed pixels above the block, the 16 pixels to its left and the corner pixel above-left. From these it forms a horizontal slope, a vertical slope and a base term. A weighted-difference datapath folds the neighbour row and the neighbour column in eight steps, one step per clock. A scaling stage then turns each raw gradient into a slope. The stage has a 2-bit selector with three rounding variants.

A caller holds the neighbours and the selector valid and pulses `start` for one cycle. The unit captures everything on that edge and accumulates for eight cycles. It then registers the results and raises `done`. The results and `done` hold until the next accepted start. A start that arrives during a computation is dropped.

Top module: `plane_param_unit`

## Requirements
- R1: The raw horizontal gradient is the sum over k = 1..8 of k × (T[7+k] − T[7−k]), where T[n] is top pixel n (bits 8n+7:8n of `top_px`) and T[−1] is the `corner` pixel.
- R2: The raw vertical gradient is the sum over k = 1..8 of k × (L[7+k] − L[7−k]), where L[n] is left pixel n (bits 8n+7:8n of `left_px`) and L[−1] is the `corner` pixel.
- R3: `base_out` equals 16 × (L[15] + T[15] + 1).
- R4: With `mode` = 0, each slope is floor((5 × raw + 32) / 64), which is an arithmetic right shift by 6.
- R5: With `mode` = 1, each slope is floor((raw + floor(raw / 4)) / 16), using arithmetic shifts.
- R6: With `mode` = 2, each scaled value is trunc(5 × trunc(raw / 4) / 16), with both divisions truncating toward zero. `slope_h` then carries the scaled vertical gradient and `slope_v` carries the scaled horizontal gradient.
- R7: With `mode` = 3, the outputs equal those of `mode` = 0.
- R8: After reset `done` is 0 and all outputs are 0. An accepted start clears `done` on the next edge. `done` is 1 after the ninth rising edge that follows the edge sampling the start.
- R9: While `done` is 1 and `start` is low, `done`, `slope_h`, `slope_v` and `base_out` stay unchanged.
- R10: A start that arrives while a computation is in progress is ignored. The results are those of the inputs captured at the accepted start, and the latency is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; captures inputs when the unit is idle |
| mode | input | 2 | Slope scaling variant (0, 1, 2; 3 acts as 0) |
| top_px | input | 128 | Sixteen 8-bit pixels above the block, pixel n in bits 8n+7:8n |
| left_px | input | 128 | Sixteen 8-bit pixels left of the block, pixel n in bits 8n+7:8n |
| corner | input | 8 | Pixel above-left of the block |
| done | output | 1 | Results valid |
| slope_h | output | 18 | Signed horizontal slope |
| slope_v | output | 18 | Signed vertical slope |
| base_out | output | 18 | Base term |

## Verification
The hardest case to reach from the ports is a negative raw gradient whose value separates floor from truncation. Examples are raw values of −1, −3 and −5, and any value near ±9180. Only these cases expose a wrong shift or division in one of the three modes. The stimulus reaches them in three ways. Hand-built edges push one side of the row or column to 255 and the other to 0. Single-pixel sweeps step one pixel through many values and so walk the raw gradient through small negative values. Pseudo-random neighbour sets are run through all four selector values. A second start is also injected in the middle of a computation, with different data, to show that it leaves no mark.

// File: rtl/plane_pkg.sv
package plane_pkg;
    localparam int PIX_W   = 8;
    localparam int N_PIX   = 16;
    localparam int HALF    = N_PIX / 2;
    localparam int ACC_W   = 18;
    localparam int STEP_W  = $clog2(HALF + 1);
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int RAW_MAX = (HALF * (HALF + 1) / 2) * PIX_MAX;

    typedef logic [N_PIX-1:0][PIX_W-1:0] pix_line_t;
    typedef logic signed [ACC_W-1:0]     grad_t;

    typedef enum logic [1:0] {
        SC_ROUND64 = 2'd0,
        SC_SHIFTQ  = 2'd1,
        SC_TRUNC   = 2'd2,
        SC_RSVD    = 2'd3
    } scale_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } unit_state_t;

    typedef struct packed {
        grad_t h;
        grad_t v;
    } grad_pair_t;

    function automatic grad_t base_term(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
        grad_t s;
        s = grad_t'(a) + grad_t'(b) + grad_t'(1);
        return s <<< 4;
    endfunction
endpackage

// File: rtl/plane_grad_mac.sv
module plane_grad_mac
    import plane_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                en,
    input  logic [STEP_W-1:0]   idx,
    input  pix_line_t           line,
    input  logic [PIX_W-1:0]    corner,
    output grad_t               acc
);
    logic [PIX_W-1:0] hi_px, lo_px;
    grad_t            diff, term;

    always_comb begin
        hi_px = line[(HALF - 1) + int'(idx)];
        if (int'(idx) == HALF)
            lo_px = corner;
        else
            lo_px = line[(HALF - 1) - int'(idx)];
        diff = grad_t'(hi_px) - grad_t'(lo_px);
        term = diff * grad_t'(idx);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (en)
            acc <= acc + term;
    end

    p_acc_range_r1: assert property (@(posedge clk) disable iff (rst)
        (acc <= grad_t'(RAW_MAX)) && (acc >= -grad_t'(RAW_MAX)));
endmodule

// File: rtl/plane_slope_scale.sv
module plane_slope_scale
    import plane_pkg::*;
(
    input  grad_t      raw,
    input  scale_sel_t sel,
    output grad_t      scaled
);
    localparam grad_t FOUR    = grad_t'(4);
    localparam grad_t SIXTEEN = grad_t'(16);

    grad_t m0_sum, m1_sum, q4, q4x5;

    always_comb begin
        m0_sum = (raw <<< 2) + raw + grad_t'(32);
        m1_sum = raw + (raw >>> 2);
        q4     = raw / FOUR;
        q4x5   = (q4 <<< 2) + q4;
        unique case (sel)
            SC_SHIFTQ: scaled = m1_sum >>> 4;
            SC_TRUNC:  scaled = q4x5 / SIXTEEN;
            default:   scaled = m0_sum >>> 6;
        endcase
    end

    always_comb begin
        if (sel == SC_TRUNC)
            p_trunc_sign_r6: assert ((raw >= 0) ? (scaled >= 0) : (scaled <= 0));
    end
endmodule

// File: rtl/plane_param_unit.sv
module plane_param_unit
    import plane_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [1:0]                mode,
    input  logic [N_PIX*PIX_W-1:0]    top_px,
    input  logic [N_PIX*PIX_W-1:0]    left_px,
    input  logic [PIX_W-1:0]          corner,
    output logic                      done,
    output logic signed [ACC_W-1:0]   slope_h,
    output logic signed [ACC_W-1:0]   slope_v,
    output logic [ACC_W-1:0]          base_out
);
    unit_state_t       state;
    logic [STEP_W-1:0] step;
    scale_sel_t        sel_q;
    pix_line_t         line_q [2];
    logic [PIX_W-1:0]  corner_q;
    logic              accept;
    grad_pair_t        raw, scl;
    grad_t             raw_arr [2];
    grad_t             scl_arr [2];

    assign accept = start && (state == ST_IDLE);

    for (genvar a = 0; a < 2; a++) begin : g_axis
        plane_grad_mac u_mac (
            .clk    (clk),
            .rst    (rst),
            .clear  (accept),
            .en     (state == ST_RUN),
            .idx    (step),
            .line   (line_q[a]),
            .corner (corner_q),
            .acc    (raw_arr[a])
        );
        plane_slope_scale u_scale (
            .raw    (raw_arr[a]),
            .sel    (sel_q),
            .scaled (scl_arr[a])
        );
    end

    assign raw.h = raw_arr[0];
    assign raw.v = raw_arr[1];
    assign scl.h = scl_arr[0];
    assign scl.v = scl_arr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= '0;
            sel_q     <= SC_ROUND64;
            line_q[0] <= '0;
            line_q[1] <= '0;
            corner_q  <= '0;
            done      <= 1'b0;
            slope_h   <= '0;
            slope_v   <= '0;
            base_out  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    line_q[0] <= pix_line_t'(top_px);
                    line_q[1] <= pix_line_t'(left_px);
                    corner_q  <= corner;
                    sel_q     <= scale_sel_t'(mode);
                    step      <= STEP_W'(1);
                    done      <= 1'b0;
                    state     <= ST_RUN;
                end
                ST_RUN: begin
                    step <= step + STEP_W'(1);
                    if (int'(step) == HALF)
                        state <= ST_FIN;
                end
                ST_FIN: begin
                    if (sel_q == SC_TRUNC) begin
                        slope_h <= scl.v;
                        slope_v <= scl.h;
                    end else begin
                        slope_h <= scl.h;
                        slope_v <= scl.v;
                    end
                    base_out <= base_term(line_q[0][N_PIX-1], line_q[1][N_PIX-1]);
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (!done && state == ST_RUN));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(slope_h) && $stable(slope_v) && $stable(base_out)));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && int'(step) != HALF) |=> (state == ST_RUN && step == $past(step) + STEP_W'(1)));

    p_raw_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |-> ((raw.h <= grad_t'(RAW_MAX)) && (raw.v >= -grad_t'(RAW_MAX))));
endmodule

// File: tb/plane_param_unit_tb_top.sv
module plane_param_unit_tb_top;
    logic         clk = 0;
    logic         rst = 1;
    logic         start = 0;
    logic [1:0]   mode = 0;
    logic [127:0] top_px = '0;
    logic [127:0] left_px = '0;
    logic [7:0]   corner = 0;
    logic         done;
    logic signed [17:0] slope_h, slope_v;
    logic [17:0]  base_out;

    int checks = 0;
    int errors = 0;
    int tp [16];
    int lp [16];
    int cp;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    plane_param_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .top_px(top_px), .left_px(left_px), .corner(corner),
        .done(done), .slope_h(slope_h), .slope_v(slope_v), .base_out(base_out)
    );

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fdiv(input int a, input int b);
        if (a >= 0) return a / b;
        return -((-a + b - 1) / b);
    endfunction

    function automatic int rawg(input bit vert);
        int s = 0;
        for (int k = 1; k <= 8; k++) begin
            int hi, lo;
            hi = vert ? lp[7+k] : tp[7+k];
            lo = (k == 8) ? cp : (vert ? lp[7-k] : tp[7-k]);
            s += k * (hi - lo);
        end
        return s;
    endfunction

    function automatic int scale(input int r, input int m);
        if (m == 1) return fdiv(r + fdiv(r, 4), 16);
        if (m == 2) return (5 * (r / 4)) / 16;
        return fdiv(5 * r + 32, 64);
    endfunction

    function automatic int rnd8();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[7:0] ^ lfsr[23:16]);
    endfunction

    task automatic load();
        for (int n = 0; n < 16; n++) begin
            top_px[8*n +: 8]  = 8'(tp[n]);
            left_px[8*n +: 8] = 8'(lp[n]);
        end
        corner = 8'(cp);
    endtask

    task automatic run(input int m, input bit check_lat);
        int n, rh, rv, eh, ev;
        load();
        mode = 2'(m);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        n = 1;
        if (check_lat) chk("R8 done cleared", int'(done), 0);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (check_lat) chk("R8 latency", n, 10);
        rh = rawg(0);
        rv = rawg(1);
        if (m == 2) begin
            eh = scale(rv, 2);
            ev = scale(rh, 2);
        end else begin
            eh = scale(rh, m);
            ev = scale(rv, m);
        end
        chk($sformatf("R1 R4 R5 R6 R7 slope_h m%0d", m), int'(slope_h), eh);
        chk($sformatf("R2 R4 R5 R6 R7 slope_v m%0d", m), int'(slope_v), ev);
        chk("R3 base", int'(base_out), 16 * (lp[15] + tp[15] + 1));
    endtask

    task automatic fill(input int t, input int l, input int c);
        for (int n = 0; n < 16; n++) begin
            tp[n] = t;
            lp[n] = l;
        end
        cp = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset slope_h", int'(slope_h), 0);
        chk("R8 reset base", int'(base_out), 0);

        // extreme edges, all modes (R1 R2 R4-R7)
        for (int m = 0; m < 4; m++) begin
            fill(0, 0, 0);
            for (int n = 8; n < 16; n++) begin tp[n] = 255; lp[n] = 0; end
            for (int n = 0; n < 8; n++) lp[n] = 255;
            cp = 0;
            run(m, 1);
            fill(255, 0, 255);
            run(m, 0);
        end

        // single-pixel sweeps walk raw through small negative/positive values
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 256; v += 3) begin
                fill(128, 128, 128);
                tp[6] = v;
                lp[14] = 255 - v;
                run(m, 0);
            end
        end

        // pseudo-random neighbour sets
        for (int it = 0; it < 120; it++) begin
            for (int n = 0; n < 16; n++) begin tp[n] = rnd8(); lp[n] = rnd8(); end
            cp = rnd8();
            run(it % 4, 0);
        end

        // R9: hold after done with no start
        fill(10, 200, 90);
        run(0, 0);
        begin
            int h0, v0, b0;
            h0 = int'(slope_h); v0 = int'(slope_v); b0 = int'(base_out);
            fill(0, 255, 3);
            load();
            repeat (15) @(negedge clk);
            chk("R9 done held", int'(done), 1);
            chk("R9 slope_h held", int'(slope_h), h0);
            chk("R9 slope_v held", int'(slope_v), v0);
            chk("R9 base held", int'(base_out), b0);
        end

        // R10: start during computation ignored
        begin
            int n, eh, ev, eb;
            fill(0, 0, 0);
            for (int k = 0; k < 16; k++) begin tp[k] = 16 * k; lp[k] = 255 - 15 * k; end
            cp = 77;
            eh = scale(rawg(0), 1);
            ev = scale(rawg(1), 1);
            eb = 16 * (lp[15] + tp[15] + 1);
            load();
            mode = 2'd1;
            @(negedge clk); start = 1;
            @(negedge clk); start = 0; n = 1;
            repeat (3) begin @(negedge clk); n++; end
            top_px = {16{8'hFF}}; left_px = '0; corner = 8'h00; mode = 2'd2;
            start = 1;
            @(negedge clk); start = 0; n++;
            while (!done && n < 40) begin @(negedge clk); n++; end
            chk("R10 latency", n, 10);
            chk("R10 slope_h", int'(slope_h), eh);
            chk("R10 slope_v", int'(slope_v), ev);
            chk("R10 base", int'(base_out), eb);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule